// File: doc/BRIEF.md
# Multi-Retire Reorder Buffer

This block keeps speculative micro-operations in program order. The front end claims up to three consecutive ring slots per cycle and gives each a destination register. Execution units then return results in any order, addressed by slot index. A writeback may also mark its slot as faulting, which covers a trap, an interrupt or a mispredicted branch. Each cycle the block looks at the oldest slots and commits the finished ones, as a contiguous run of up to three, into a small architectural register file. It has no other way to commit anything.

The run of commits stops at the first slot that has not finished or that carries a fault. When the oldest slot itself is finished and faulting, the block drives a one-cycle flush that carries that slot's index. It writes nothing for that slot and returns the whole ring to empty. A combinational read port on the register file lets the surrounding logic see the committed state.

Top module: `rob_core`

## Requirements
- R1: After reset the occupancy is 0, no commit or flush is signalled, and every architectural register reads 0.
- R2: A granted allocation of N slots (N = 1..3) takes slots tail, tail+1, …, tail+N-1, and `alloc_idx_o` reports the first of them. Lane k's destination is `alloc_dst_i[3k+2:3k]`. Occupancy then changes by N minus the commit count.
- R3: A request is refused (`alloc_ok_o` = 0) when the free slots (40 minus the occupancy) are fewer than the count requested. A refused request changes neither occupancy nor tail.
- R4: A completed slot does not commit while any older slot is still pending.
- R5: Up to three slots commit in one cycle, and `ret_cnt_o` gives how many.
- R6: A committed slot writes its result into its destination register at the clock edge. When several commits in one cycle target the same register, the youngest value remains.
- R7: A commit run stops at the first slot that is not done or is faulting. The slots beyond it stay in the ring.
- R8: When the oldest slot is done and faulting, `flush_o` is 1 for one cycle and `flush_idx_o` gives its index. Nothing is committed for that slot, occupancy returns to 0, and the next allocation starts at slot 0.
- R9: No allocation is granted in a flush cycle.
- R10: Slot indices wrap from 39 to 0, both within a single multi-slot allocation and across allocations, and commits follow the wrapped order.
- R11: `rd_data_o` shows the register selected by `rd_addr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_cnt_i | input | 2 | Number of slots requested (0 = none) |
| alloc_dst_i | input | 9 | Destination register per lane, lane 0 in the low bits |
| alloc_ok_o | output | 1 | Request granted this cycle |
| alloc_idx_o | output | 6 | Index of the first slot granted (current tail) |
| wb_valid_i | input | 1 | Writeback strobe |
| wb_idx_i | input | 6 | Slot being completed |
| wb_data_i | input | 32 | Result value |
| wb_fault_i | input | 1 | Completion carries a fault or mispredict |
| ret_cnt_o | output | 2 | Slots committed this cycle |
| flush_o | output | 1 | Oldest slot faulted; ring is emptied |
| flush_idx_o | output | 6 | Index of the faulting slot |
| occ_o | output | 6 | Current occupancy |
| rd_addr_i | input | 3 | Register file read address |
| rd_data_o | output | 32 | Register file read data |

## Verification
The bench builds the block with its default parameters: a ring of 40 slots, three allocation lanes, three commit lanes and eight 32-bit registers. A ring of 40 is not a power of two, so the wrap from 39 to 0 is exercised by arithmetic that a simple counter overflow would get wrong. With three lanes, a single allocation can straddle the wrap. The ring size is small enough that the bench can fill it completely, see requests refused at 39 and at 40 slots, and then drain it one slot at a time.

// File: rtl/rob_pkg.sv
package rob_pkg;
   localparam int ROB_DEPTH_DEF = 40;
   localparam int ROB_LANES_DEF = 3;

   typedef struct packed {
      logic done;
      logic fault;
   } rob_flag_t;

   // modular add for offsets no larger than depth
   function automatic int ring_add(input int base, input int off, input int depth);
      int s;
      s = base + off;
      return (s >= depth) ? s - depth : s;
   endfunction
endpackage

// File: rtl/rob_arf.sv
module rob_arf #(
   parameter int NREGS  = 8,
   parameter int XLEN   = 32,
   parameter int LANES  = 3,
   parameter bit ZERO_INIT = 1'b1,
   localparam int RW = $clog2(NREGS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [LANES-1:0]               we_i,
   input  logic [LANES-1:0][RW-1:0]       wa_i,
   input  logic [LANES-1:0][XLEN-1:0]     wd_i,
   input  logic [RW-1:0]                  ra_i,
   output logic [XLEN-1:0]                rd_o
);
   logic [NREGS-1:0][XLEN-1:0] regs_q;

   generate
      if (ZERO_INIT) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               regs_q <= '0;
            end else begin
               // ascending lane order: the youngest write wins
               for (int k = 0; k < LANES; k++) begin
                  if (we_i[k]) regs_q[wa_i[k]] <= wd_i[k];
               end
            end
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            for (int k = 0; k < LANES; k++) begin
               if (we_i[k]) regs_q[wa_i[k]] <= wd_i[k];
            end
         end
      end
   endgenerate

   assign rd_o = regs_q[ra_i];
endmodule

// File: rtl/rob_retire_scan.sv
module rob_retire_scan
   import rob_pkg::*;
#(
   parameter int DEPTH = 40,
   parameter int LANES = 3,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int RN_W  = $clog2(LANES + 1)
) (
   input  logic [IDX_W-1:0]              head_i,
   input  logic [CNT_W-1:0]              occ_i,
   input  rob_flag_t [DEPTH-1:0]         flag_i,
   output logic [RN_W-1:0]               ret_n_o,
   output logic [LANES-1:0][IDX_W-1:0]   lane_idx_o,
   output logic                          head_flush_o
);
   logic [LANES-1:0] lane_ok;

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         assign lane_idx_o[k] = IDX_W'(ring_add(int'(head_i), k, DEPTH));
         assign lane_ok[k]    = (int'(occ_i) > k) &&
                                flag_i[lane_idx_o[k]].done &&
                                !flag_i[lane_idx_o[k]].fault;
      end
   endgenerate

   always_comb begin
      logic run;
      int   n;
      run = 1'b1;
      n   = 0;
      for (int k = 0; k < LANES; k++) begin
         run = run & lane_ok[k];
         if (run) n = n + 1;
      end
      ret_n_o = RN_W'(n);
   end

   assign head_flush_o = (occ_i != '0) && flag_i[head_i].done && flag_i[head_i].fault;
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store
   import rob_pkg::*;
#(
   parameter int DEPTH   = 40,
   parameter int XLEN    = 32,
   parameter int NREGS   = 8,
   parameter int ALLOC_W = 3,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int RW     = $clog2(NREGS),
   localparam int AN_W   = $clog2(ALLOC_W + 1)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           clr_i,
   input  logic                           alloc_en_i,
   input  logic [AN_W-1:0]                alloc_n_i,
   input  logic [IDX_W-1:0]               tail_i,
   input  logic [ALLOC_W-1:0][RW-1:0]     alloc_dst_i,
   input  logic                           wb_valid_i,
   input  logic [IDX_W-1:0]               wb_idx_i,
   input  logic [XLEN-1:0]                wb_data_i,
   input  logic                           wb_fault_i,
   output rob_flag_t [DEPTH-1:0]          flag_o,
   output logic [DEPTH-1:0][RW-1:0]       dst_o,
   output logic [DEPTH-1:0][XLEN-1:0]     data_o
);
   rob_flag_t [DEPTH-1:0]      flag_q;
   logic [DEPTH-1:0][RW-1:0]   dst_q;
   logic [DEPTH-1:0][XLEN-1:0] data_q;
   logic                       wb_hit;

   assign wb_hit = wb_valid_i && (int'(wb_idx_i) < DEPTH);

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         flag_q <= '0;
      end else begin
         if (wb_hit) flag_q[wb_idx_i] <= '{done: 1'b1, fault: wb_fault_i};
         if (alloc_en_i) begin
            for (int k = 0; k < ALLOC_W; k++) begin
               if (k < int'(alloc_n_i))
                  flag_q[IDX_W'(ring_add(int'(tail_i), k, DEPTH))] <= '0;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wb_hit) data_q[wb_idx_i] <= wb_data_i;
      if (alloc_en_i) begin
         for (int k = 0; k < ALLOC_W; k++) begin
            if (k < int'(alloc_n_i))
               dst_q[IDX_W'(ring_add(int'(tail_i), k, DEPTH))] <= alloc_dst_i[k];
         end
      end
   end

   assign flag_o = flag_q;
   assign dst_o  = dst_q;
   assign data_o = data_q;
endmodule

// File: rtl/rob_core.sv
module rob_core
   import rob_pkg::*;
#(
   parameter int DEPTH   = ROB_DEPTH_DEF,
   parameter int ALLOC_W = ROB_LANES_DEF,
   parameter int RET_W   = ROB_LANES_DEF,
   parameter int NREGS   = 8,
   parameter int XLEN    = 32,
   parameter bit ARF_ZERO_INIT = 1'b1,
   localparam int IDX_W  = $clog2(DEPTH),
   localparam int CNT_W  = $clog2(DEPTH + 1),
   localparam int AN_W   = $clog2(ALLOC_W + 1),
   localparam int RN_W   = $clog2(RET_W + 1),
   localparam int RW     = $clog2(NREGS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [AN_W-1:0]         alloc_cnt_i,
   input  logic [ALLOC_W*RW-1:0]   alloc_dst_i,
   output logic                    alloc_ok_o,
   output logic [IDX_W-1:0]        alloc_idx_o,
   input  logic                    wb_valid_i,
   input  logic [IDX_W-1:0]        wb_idx_i,
   input  logic [XLEN-1:0]         wb_data_i,
   input  logic                    wb_fault_i,
   output logic [RN_W-1:0]         ret_cnt_o,
   output logic                    flush_o,
   output logic [IDX_W-1:0]        flush_idx_o,
   output logic [CNT_W-1:0]        occ_o,
   input  logic [RW-1:0]           rd_addr_i,
   output logic [XLEN-1:0]         rd_data_o
);
   generate
      if (DEPTH < 2)                         begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (ALLOC_W < 1 || ALLOC_W > DEPTH)    begin : g_bad_alloc $error("ALLOC_W out of range"); end
      if (RET_W < 1 || RET_W > DEPTH)        begin : g_bad_ret   $error("RET_W out of range"); end
      if (NREGS < 2)                         begin : g_bad_regs  $error("NREGS must be at least 2"); end
   endgenerate

   logic [IDX_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] occ_q;

   rob_flag_t [DEPTH-1:0]        flag;
   logic [DEPTH-1:0][RW-1:0]     dst;
   logic [DEPTH-1:0][XLEN-1:0]   data;
   logic [RN_W-1:0]              ret_n;
   logic [RET_W-1:0][IDX_W-1:0]  lane_idx;
   logic                         flush;
   logic                         grant;
   logic [ALLOC_W-1:0][RW-1:0]   dst_lanes;

   logic [RET_W-1:0]             arf_we;
   logic [RET_W-1:0][RW-1:0]     arf_wa;
   logic [RET_W-1:0][XLEN-1:0]   arf_wd;

   assign dst_lanes = alloc_dst_i;
   assign grant = (alloc_cnt_i != '0) && !flush &&
                  (int'(occ_q) + int'(alloc_cnt_i) <= DEPTH);

   rob_entry_store #(
      .DEPTH(DEPTH), .XLEN(XLEN), .NREGS(NREGS), .ALLOC_W(ALLOC_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .clr_i(flush),
      .alloc_en_i(grant), .alloc_n_i(alloc_cnt_i), .tail_i(tail_q),
      .alloc_dst_i(dst_lanes),
      .wb_valid_i(wb_valid_i), .wb_idx_i(wb_idx_i),
      .wb_data_i(wb_data_i), .wb_fault_i(wb_fault_i),
      .flag_o(flag), .dst_o(dst), .data_o(data)
   );

   rob_retire_scan #(.DEPTH(DEPTH), .LANES(RET_W)) u_scan (
      .head_i(head_q), .occ_i(occ_q), .flag_i(flag),
      .ret_n_o(ret_n), .lane_idx_o(lane_idx), .head_flush_o(flush)
   );

   generate
      for (genvar k = 0; k < RET_W; k++) begin : g_commit
         assign arf_we[k] = (k < int'(ret_n));
         assign arf_wa[k] = dst[lane_idx[k]];
         assign arf_wd[k] = data[lane_idx[k]];
      end
   endgenerate

   rob_arf #(
      .NREGS(NREGS), .XLEN(XLEN), .LANES(RET_W), .ZERO_INIT(ARF_ZERO_INIT)
   ) u_arf (
      .clk(clk), .rst_n(rst_n),
      .we_i(arf_we), .wa_i(arf_wa), .wd_i(arf_wd),
      .ra_i(rd_addr_i), .rd_o(rd_data_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
      end else begin
         occ_q  <= CNT_W'(int'(occ_q) + (grant ? int'(alloc_cnt_i) : 0) - int'(ret_n));
         head_q <= IDX_W'(ring_add(int'(head_q), int'(ret_n), DEPTH));
         if (grant) tail_q <= IDX_W'(ring_add(int'(tail_q), int'(alloc_cnt_i), DEPTH));
      end
   end

   assign alloc_ok_o  = grant;
   assign alloc_idx_o = tail_q;
   assign ret_cnt_o   = ret_n;
   assign flush_o     = flush;
   assign flush_idx_o = head_q;
   assign occ_o       = occ_q;
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
   parameter int DEPTH = 40,
   parameter int AN_W  = 2,
   parameter int RN_W  = 2,
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AN_W-1:0]  alloc_cnt,
   input logic             alloc_ok,
   input logic [RN_W-1:0]  ret_cnt,
   input logic             flush,
   input logic [CNT_W-1:0] occ
);
   p_occ_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      int'(occ) <= DEPTH);

   p_refuse_when_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_cnt != '0 && int'(occ) + int'(alloc_cnt) > DEPTH) |-> !alloc_ok);

   p_occ_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !flush |=> int'(occ) == int'($past(occ)) +
                 ($past(alloc_ok) ? int'($past(alloc_cnt)) : 0) - int'($past(ret_cnt)));

   p_commit_le_occ_r5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ret_cnt) <= int'(occ));

   p_flush_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> ret_cnt == '0);

   p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (occ == '0 && !flush));

   p_flush_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |-> !alloc_ok);
endmodule

bind rob_core rob_core_chk #(
   .DEPTH(DEPTH), .AN_W(AN_W), .RN_W(RN_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_cnt(alloc_cnt_i), .alloc_ok(alloc_ok_o),
   .ret_cnt(ret_cnt_o), .flush(flush_o), .occ(occ_o)
);

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  alloc_cnt = '0;
   logic [8:0]  alloc_dst = '0;
   logic        alloc_ok;
   logic [5:0]  alloc_idx;
   logic        wb_valid = 1'b0;
   logic [5:0]  wb_idx = '0;
   logic [31:0] wb_data = '0;
   logic        wb_fault = 1'b0;
   logic [1:0]  ret_cnt;
   logic        flush;
   logic [5:0]  flush_idx;
   logic [5:0]  occ;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int nchk = 0;
   int nerr = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   rob_core dut_i (
      .clk(clk), .rst_n(rst_n),
      .alloc_cnt_i(alloc_cnt), .alloc_dst_i(alloc_dst),
      .alloc_ok_o(alloc_ok), .alloc_idx_o(alloc_idx),
      .wb_valid_i(wb_valid), .wb_idx_i(wb_idx), .wb_data_i(wb_data), .wb_fault_i(wb_fault),
      .ret_cnt_o(ret_cnt), .flush_o(flush), .flush_idx_o(flush_idx), .occ_o(occ),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic chk_reg(input string req, input int r, input logic [31:0] exp);
      rd_addr = 3'(r);
      #1;
      chk(req, rd_data, exp);
   endtask

   // request n slots; returns grant and first index seen before the edge
   task automatic req_alloc(input int n, input int d0, input int d1, input int d2,
                            output logic ok, output logic [5:0] idx);
      alloc_cnt = 2'(n);
      alloc_dst = {3'(d2), 3'(d1), 3'(d0)};
      #1;
      ok  = alloc_ok;
      idx = alloc_idx;
      tick();
      alloc_cnt = '0;
   endtask

   task automatic do_wb(input int idx, input logic [31:0] d, input bit f);
      wb_valid = 1'b1;
      wb_idx   = 6'(idx);
      wb_data  = d;
      wb_fault = f;
      tick();
      wb_valid = 1'b0;
      wb_fault = 1'b0;
   endtask

   task automatic t_reset();
      #1;
      chk("R1 occ", 32'(occ), 0);
      chk("R1 ret", 32'(ret_cnt), 0);
      chk("R1 flush", 32'(flush), 0);
      for (int r = 0; r < 8; r++) chk_reg("R1/R11 reg zero", r, 0);
   endtask

   task automatic t_alloc_order();
      logic ok; logic [5:0] idx;
      req_alloc(3, 1, 2, 3, ok, idx);
      chk("R2 grant3", 32'(ok), 1);
      chk("R2 idx first", 32'(idx), 0);
      req_alloc(2, 4, 5, 0, ok, idx);
      chk("R2 grant2", 32'(ok), 1);
      chk("R2 idx second", 32'(idx), 3);
      #1;
      chk("R2 occ", 32'(occ), 5);
   endtask

   task automatic t_out_of_order();
      do_wb(2, 32'hA, 0);
      #1; chk("R4 young done, head pending", 32'(ret_cnt), 0);
      do_wb(1, 32'hB, 0);
      #1; chk("R4 still waiting", 32'(ret_cnt), 0);
      do_wb(0, 32'hC, 0);
      #1; chk("R5 three commit", 32'(ret_cnt), 3);
      tick();
      #1; chk("R5 occ after commit", 32'(occ), 2);
      chk_reg("R6 r1", 1, 32'hC);
      chk_reg("R6 r2", 2, 32'hB);
      chk_reg("R6 r3", 3, 32'hA);
      do_wb(4, 32'hE, 0);
      #1; chk("R7 stop at pending slot", 32'(ret_cnt), 0);
      do_wb(3, 32'hD, 0);
      #1; chk("R7 two commit", 32'(ret_cnt), 2);
      tick();
      #1; chk("R7 occ empty", 32'(occ), 0);
      chk_reg("R6 r4", 4, 32'hD);
      chk_reg("R6 r5", 5, 32'hE);
   endtask

   task automatic t_same_dst();
      logic ok; logic [5:0] idx;
      req_alloc(3, 6, 6, 6, ok, idx);
      chk("R2 idx after wrap-free run", 32'(idx), 5);
      do_wb(7, 32'h77, 0);
      do_wb(6, 32'h66, 0);
      do_wb(5, 32'h55, 0);
      #1; chk("R5 three same dst", 32'(ret_cnt), 3);
      tick();
      chk_reg("R6 youngest wins", 6, 32'h77);
   endtask

   task automatic t_fault();
      logic ok; logic [5:0] idx;
      req_alloc(3, 1, 2, 7, ok, idx);
      chk("R2 idx fault group", 32'(idx), 8);
      do_wb(9, 32'h99, 1);
      do_wb(10, 32'hAA, 0);
      do_wb(8, 32'hD8, 0);
      #1;
      chk("R7 stop at flagged", 32'(ret_cnt), 1);
      chk("R8 no flush yet", 32'(flush), 0);
      tick();
      alloc_cnt = 2'd1;
      alloc_dst = '0;
      #1;
      chk("R8 flush raised", 32'(flush), 1);
      chk("R8 flush index", 32'(flush_idx), 9);
      chk("R8 no commit on flush", 32'(ret_cnt), 0);
      chk("R9 no grant in flush", 32'(alloc_ok), 0);
      tick();
      alloc_cnt = '0;
      #1;
      chk("R8 occ cleared", 32'(occ), 0);
      chk("R8 one-cycle flush", 32'(flush), 0);
      chk_reg("R8 older slot committed", 1, 32'hD8);
      chk_reg("R8 faulting slot not written", 2, 32'hB);
      chk_reg("R8 younger slot dropped", 7, 0);
      req_alloc(3, 0, 0, 0, ok, idx);
      chk("R8 tail restarts", 32'(idx), 0);
      do_wb(0, 32'h0, 0);
      do_wb(1, 32'h0, 0);
      do_wb(2, 32'h0, 0);
      tick();
      #1; chk("R8 drained", 32'(occ), 0);
   endtask

   task automatic t_full_wrap();
      logic ok; logic [5:0] idx;
      for (int j = 0; j < 12; j++) req_alloc(3, 0, 0, 0, ok, idx);
      #1; chk("R2 occ after fill", 32'(occ), 36);
      req_alloc(3, 4, 5, 6, ok, idx);
      chk("R10 straddling grant", 32'(ok), 1);
      chk("R10 first idx 39", 32'(idx), 39);
      req_alloc(3, 0, 0, 0, ok, idx);
      chk("R3 refuse 3 of 1 free", 32'(ok), 0);
      req_alloc(2, 0, 0, 0, ok, idx);
      chk("R3 refuse 2 of 1 free", 32'(ok), 0);
      #1; chk("R3 occ unchanged", 32'(occ), 39);
      req_alloc(1, 7, 0, 0, ok, idx);
      chk("R3 last slot granted", 32'(ok), 1);
      chk("R10 idx after wrap", 32'(idx), 2);
      req_alloc(1, 0, 0, 0, ok, idx);
      chk("R3 refuse when full", 32'(ok), 0);
      #1; chk("R3 occ full", 32'(occ), 40);
      for (int i = 0; i < 40; i++) begin
         int s;
         s = (3 + i) % 40;
         do_wb(s, 32'h1000 + 32'(s), 0);
      end
      tick();
      tick();
      #1; chk("R10 drained", 32'(occ), 0);
      chk_reg("R10 slot 38", 0, 32'h1026);
      chk_reg("R10 slot 39", 4, 32'h1027);
      chk_reg("R10 slot 0", 5, 32'h1000);
      chk_reg("R10 slot 1", 6, 32'h1001);
      chk_reg("R10 slot 2", 7, 32'h1002);
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_alloc_order();
      t_out_of_order();
      t_same_dst();
      t_fault();
      t_full_wrap();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("CHECKS %0d ERRORS %0d", nchk, nerr);
         $finish;
      end
   end
endmodule